// File: doc/BRIEF.md
# Single-Accumulator Fetch/Execute Processor Core

This block is a small 16-bit processor built around one data register, the accumulator. It runs a strict two-phase loop. First it reads the word at the program counter into its instruction register and steps the counter. Then it decodes and executes that word. It keeps doing this until it meets a halt instruction, after which it sits idle with a status output raised.

The core drives a single-ported, word-addressed memory. It has one address bus, separate read and write data buses, and one read strobe and one write strobe. A read returns data one cycle after the strobe. The core always spends that cycle waiting, both when it fetches an instruction and when it loads an operand.

A testbench or a host loads a program into memory, releases reset, and waits for the halt output. It then inspects memory for the results.

Top module: `acc_core`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the program counter, the instruction register and the accumulator, and puts the core in the fetch phase. In the first cycle after release, the core presents a read at address 0 with the write strobe and `halted` low.
- R2: An instruction word carries its opcode in bits [15:12] and a 12-bit direct address in bits [11:0].
- R3: A fetch raises `mem_rd` for one cycle with `mem_addr` equal to the program counter. It then waits one cycle with no strobe, loads the returned word into the instruction register and adds one to the program counter. The counter wraps from 0xFFF to 0x000.
- R4: Opcode 0x1 (load) reads the word at the address field and places it in the accumulator.
- R5: Opcode 0x5 (add) reads the word at the address field and adds it to the accumulator modulo 2^16, with no carry kept.
- R6: Opcode 0x2 (store) raises `mem_wr` for one cycle, with `mem_addr` equal to the address field and `mem_wdata` equal to the accumulator.
- R7: Opcode 0x8 (jump) replaces the program counter with the address field, so the next fetch comes from that target.
- R8: Opcode 0xF (halt) raises `halted`, which then stays high until reset. While halted, neither strobe is raised.
- R9: Every other opcode is a no-op. It makes no memory access, leaves the accumulator unchanged, and the next fetch comes from the following address.
- R10: `mem_rd` and `mem_wr` are never high in the same cycle.
- R11: Load and add take 4 cycles from the fetch strobe to the next fetch strobe. Every other instruction takes 3. After a halt has been fetched, `halted` rises 3 cycles after its fetch strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_rdata | input | 16 | Read data, valid the cycle after a read strobe |
| mem_addr | output | 12 | Word address for the current access |
| mem_wdata | output | 16 | Write data (accumulator) |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| halted | output | 1 | High while the core is in the halt state |

## Verification
The add path is swept over operand pairs that include a zero sum from wraparound, 0xFFFF plus one, and two large values whose top bits overflow. A stored sum therefore shows whether wrapping and the reload of the second operand behave. Every opcode outside the defined set is run between a load and a store. This tells a true no-op apart from one that writes memory, disturbs the accumulator or skips an address. One program jumps over a store. Another starts with a store, which shows whether reset cleared the accumulator. A third runs off the top of the address space and writes a halt into address 0 on the way, so it halts only if the counter wraps. The cycle count to `halted` is checked on every program, which exposes any extra or missing wait state.

// File: rtl/acc_pkg.sv
package acc_pkg;
  typedef enum logic [2:0] {
    PH_FETCH = 3'd0,
    PH_FWAIT = 3'd1,
    PH_EXEC  = 3'd2,
    PH_OWAIT = 3'd3,
    PH_HALT  = 3'd4
  } phase_t;

  localparam logic [3:0] OPC_LOAD  = 4'h1;
  localparam logic [3:0] OPC_STORE = 4'h2;
  localparam logic [3:0] OPC_ADD   = 4'h5;
  localparam logic [3:0] OPC_JUMP  = 4'h8;
  localparam logic [3:0] OPC_HALT  = 4'hF;
endpackage

// File: rtl/acc_decode.sv
module acc_decode #(
  parameter int OP_W = 4
) (
  input  logic [OP_W-1:0] opc,
  output logic            is_load,
  output logic            is_store,
  output logic            is_add,
  output logic            is_jump,
  output logic            is_halt
);
  import acc_pkg::*;

  always_comb begin
    is_load  = (opc == OP_W'(OPC_LOAD));
    is_store = (opc == OP_W'(OPC_STORE));
    is_add   = (opc == OP_W'(OPC_ADD));
    is_jump  = (opc == OP_W'(OPC_JUMP));
    is_halt  = (opc == OP_W'(OPC_HALT));
  end
endmodule

// File: rtl/acc_seq.sv
module acc_seq (
  input  logic clk,
  input  logic rst,
  input  logic is_load,
  input  logic is_store,
  input  logic is_add,
  input  logic is_jump,
  input  logic is_halt,
  output logic fetch_rd,
  output logic ir_load,
  output logic op_rd,
  output logic acc_load,
  output logic store_wr,
  output logic jump_take,
  output logic halted
);
  import acc_pkg::*;

  phase_t phase, phase_nx;

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_FETCH;
    else     phase <= phase_nx;
  end

  always_comb begin
    phase_nx  = phase;
    fetch_rd  = 1'b0;
    ir_load   = 1'b0;
    op_rd     = 1'b0;
    acc_load  = 1'b0;
    store_wr  = 1'b0;
    jump_take = 1'b0;
    unique case (phase)
      PH_FETCH: begin
        fetch_rd = 1'b1;
        phase_nx = PH_FWAIT;
      end
      PH_FWAIT: begin
        ir_load  = 1'b1;
        phase_nx = PH_EXEC;
      end
      PH_EXEC: begin
        phase_nx = PH_FETCH;
        if (is_load || is_add) begin
          op_rd    = 1'b1;
          phase_nx = PH_OWAIT;
        end else if (is_store) begin
          store_wr = 1'b1;
        end else if (is_jump) begin
          jump_take = 1'b1;
        end else if (is_halt) begin
          phase_nx = PH_HALT;
        end
      end
      PH_OWAIT: begin
        acc_load = 1'b1;
        phase_nx = PH_FETCH;
      end
      PH_HALT:  phase_nx = PH_HALT;
      default:  phase_nx = PH_FETCH;
    endcase
  end

  assign halted = (phase == PH_HALT);
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_rd,
  input  logic              ir_load,
  input  logic              op_rd,
  input  logic              acc_load,
  input  logic              add_sel,
  input  logic              store_wr,
  input  logic              jump_take,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] ir,
  output logic [DATA_W-1:0] acc,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_rd,
  output logic              mem_wr
);
  // next sequential address, wraps at the top of the address space
  function automatic logic [ADDR_W-1:0] pc_step(input logic [ADDR_W-1:0] p);
    return p + 1'b1;
  endfunction

  // accumulator sum, modulo 2^DATA_W
  function automatic logic [DATA_W-1:0] acc_sum(input logic [DATA_W-1:0] a,
                                                input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  logic [ADDR_W-1:0] ir_addr;
  assign ir_addr = ir[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      ir  <= '0;
      acc <= '0;
    end else begin
      if (ir_load) begin
        ir <= mem_rdata;
        pc <= pc_step(pc);
      end
      if (jump_take) pc <= ir_addr;
      if (acc_load)  acc <= add_sel ? acc_sum(acc, mem_rdata) : mem_rdata;
    end
  end

  always_comb begin
    mem_addr  = fetch_rd ? pc : ir_addr;
    mem_rd    = fetch_rd | op_rd;
    mem_wr    = store_wr;
    mem_wdata = acc;
  end
endmodule

// File: rtl/acc_core.sv
module acc_core #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              halted
);
  localparam int OP_W = DATA_W - ADDR_W;

  logic is_load, is_store, is_add, is_jump, is_halt;
  logic fetch_rd, ir_load, op_rd, acc_load, store_wr, jump_take;
  logic [ADDR_W-1:0] pc;
  logic [DATA_W-1:0] ir, acc;
  logic [OP_W-1:0]   opc;
  logic [ADDR_W-1:0] ir_addr;

  assign opc     = ir[DATA_W-1 -: OP_W];
  assign ir_addr = ir[ADDR_W-1:0];

  acc_decode #(.OP_W(OP_W)) u_dec (
    .opc(opc), .is_load(is_load), .is_store(is_store),
    .is_add(is_add), .is_jump(is_jump), .is_halt(is_halt)
  );

  acc_seq u_seq (
    .clk(clk), .rst(rst),
    .is_load(is_load), .is_store(is_store), .is_add(is_add),
    .is_jump(is_jump), .is_halt(is_halt),
    .fetch_rd(fetch_rd), .ir_load(ir_load), .op_rd(op_rd),
    .acc_load(acc_load), .store_wr(store_wr), .jump_take(jump_take),
    .halted(halted)
  );

  acc_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst(rst),
    .fetch_rd(fetch_rd), .ir_load(ir_load), .op_rd(op_rd),
    .acc_load(acc_load), .add_sel(is_add), .store_wr(store_wr),
    .jump_take(jump_take), .mem_rdata(mem_rdata),
    .pc(pc), .ir(ir), .acc(acc),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr)
  );
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              halted,
  input logic              fetch_rd,
  input logic              ir_load,
  input logic              jump_take,
  input logic [ADDR_W-1:0] pc,
  input logic [ADDR_W-1:0] ir_addr
);
  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  // R3
  fetch_addr_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_rd |-> (mem_rd && mem_addr == pc));

  // R3
  fetch_wait_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_rd |=> (!mem_rd && !mem_wr && ir_load));

  // R3
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    ir_load |=> (pc == ADDR_W'($past(pc) + 1'b1)));

  // R7
  jump_target_chk: assert property (@(posedge clk) disable iff (rst)
    jump_take |=> (pc == $past(ir_addr)));

  // R8
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R8
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!mem_rd && !mem_wr));
endmodule

bind acc_core acc_core_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_addr(mem_addr), .halted(halted), .fetch_rd(fetch_rd),
  .ir_load(ir_load), .jump_take(jump_take), .pc(pc), .ir_addr(ir_addr)
);

// File: tb/tb_acc_core.sv
module tb_acc_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_rdata = '0;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_rd, mem_wr, halted;

  logic [15:0] mem [0:4095];
  int n_chk = 0;
  int n_bad = 0;
  int clash = 0;

  always #5 clk = ~clk;

  acc_core dut (
    .clk(clk), .rst(rst), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr), .halted(halted)
  );

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  // R10 monitor
  always @(negedge clk) if (!rst && mem_rd && mem_wr) clash++;

  function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] a);
    return {op, a};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0;
  endtask

  task automatic run_prog(output int cyc);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    cyc = 0;
    while (!halted && cyc < 500) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int cyc;
    // R1: first cycle after reset release
    clear_mem();
    mem[0] = ins(4'hF, 12'h000);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(halted == 1'b0, "R1 halted in reset", halted, 0);
    rst = 1'b0;
    check(mem_rd == 1'b1 && mem_wr == 1'b0, "R1 first strobe", {mem_rd, mem_wr}, 2);
    check(mem_addr == 12'h000, "R1 first address", mem_addr, 0);
    cyc = 0;
    while (!halted && cyc < 500) begin @(negedge clk); cyc++; end
    check(cyc == 3, "R8 R11 halt latency", cyc, 3);

    // R8: stays halted and quiet
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(halted && !mem_rd && !mem_wr, "R8 idle after halt",
            {halted, mem_rd, mem_wr}, 4);
    end

    // R4 R5 R6 R2: add sweep with wrap cases
    for (int i = 0; i < 8; i++) begin
      logic [15:0] a, b, s;
      a = 16'(i * 16'h5A3C + 16'hFFF0);
      b = 16'(i * 16'h1111 + 16'h0010);
      if (i == 7) begin a = 16'hFFFF; b = 16'h0001; end
      if (i == 6) begin a = 16'h8000; b = 16'h8001; end
      s = 16'((32'(a) + 32'(b)) % 32'h10000);
      clear_mem();
      mem[0] = ins(4'h1, 12'h100);
      mem[1] = ins(4'h5, 12'h101);
      mem[2] = ins(4'h2, 12'h102);
      mem[3] = ins(4'h1, 12'h101);
      mem[4] = ins(4'h2, 12'h103);
      mem[5] = ins(4'hF, 12'h000);
      mem[12'h100] = a;
      mem[12'h101] = b;
      run_prog(cyc);
      check(mem[12'h102] == s, "R5 R6 sum", mem[12'h102], s);
      check(mem[12'h103] == b, "R4 load", mem[12'h103], b);
      check(cyc == 21, "R11 cycles add program", cyc, 21);
    end

    // R9: every undefined opcode is a no-op
    for (int op = 0; op < 16; op++) begin
      logic [15:0] v;
      if (op == 1 || op == 2 || op == 5 || op == 8 || op == 15) continue;
      v = 16'(16'h1234 + op);
      clear_mem();
      mem[0] = ins(4'h1, 12'h200);
      mem[1] = ins(op[3:0], 12'h201);
      mem[2] = ins(4'h2, 12'h202);
      mem[3] = ins(4'hF, 12'h000);
      mem[12'h200] = v;
      mem[12'h201] = 16'h0BAD;
      run_prog(cyc);
      check(mem[12'h202] == v, "R9 acc unchanged", mem[12'h202], v);
      check(mem[12'h201] == 16'h0BAD, "R9 no write", mem[12'h201], 16'h0BAD);
      check(cyc == 13, "R9 R11 no-op cycles", cyc, 13);
    end

    // R7 jump over a store; R1 accumulator cleared by reset
    clear_mem();
    mem[0]  = ins(4'h2, 12'h105);
    mem[1]  = ins(4'h1, 12'h100);
    mem[2]  = ins(4'h8, 12'h010);
    mem[3]  = ins(4'h2, 12'h101);
    mem[16] = ins(4'h2, 12'h102);
    mem[17] = ins(4'hF, 12'h000);
    mem[12'h100] = 16'h7777;
    mem[12'h105] = 16'hAAAA;
    run_prog(cyc);
    check(mem[12'h105] == 16'h0, "R1 acc reset", mem[12'h105], 0);
    check(mem[12'h101] == 16'h0, "R7 skipped store", mem[12'h101], 0);
    check(mem[12'h102] == 16'h7777, "R7 target executed", mem[12'h102], 16'h7777);
    check(cyc == 16, "R7 R11 jump cycles", cyc, 16);

    // R3 wrap: store a halt into address 0 from the top of memory
    clear_mem();
    mem[0]       = ins(4'h8, 12'hFFE);
    mem[12'hFFE] = ins(4'h1, 12'h300);
    mem[12'hFFF] = ins(4'h2, 12'h000);
    mem[12'h300] = ins(4'hF, 12'h000);
    run_prog(cyc);
    check(halted == 1'b1, "R3 pc wrap halts", halted, 1);
    check(cyc == 13, "R3 R11 wrap cycles", cyc, 13);

    check(clash == 0, "R10 strobe overlap", clash, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule